// File: doc/BRIEF.md
# Command Method Dispatcher with Macro Trigger

The dispatcher takes one command per cycle: a method index, a 32-bit argument and a flag that marks the last word of a batch. Methods below a fixed boundary are register writes. They land in a register file that downstream logic reads through a combinational port. A few of these register indices also act as side-effect methods. They load an upload pointer, store a word of macro program memory, load a bind pointer, or store an entry of the position table. Both pointers step forward by one after every store.

Methods at or above the boundary (0xE00 by default) are macro calls. A call opens on an even trigger index. Each later word must use the trigger index plus one. Every argument of the call, the first one included, is pushed into a parameter FIFO that the macro executor drains. When a call word carries the last-in-batch flag, the block raises a launch request. The request carries the program position bound to the call's table entry and the number of words the call stored. It stays up until the executor accepts it. Protocol violations never stop the stream. Each one sets its own sticky error bit, and the offending word is dropped.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset, `mstart_valid` is 0, `err` is 0, `par_empty` is 1 and every register reads 0.
- R2: A valid command whose method is below NUM_REGS writes its argument into that register, which then reads back on `reg_rd_data`. A method from NUM_REGS up to the boundary is dropped and sets `err[0]`.
- R3: With no call open, a macro-range method with bit 0 set (odd) is dropped. It sets `err[1]`, pushes nothing and opens no call.
- R4: While a call is open, any method other than trigger+1 is dropped and sets `err[2]`. This includes register methods and the trigger itself. The call stays open.
- R5: Every accepted call word, the first one included, is pushed into the parameter FIFO in arrival order. `par_data` shows the oldest word and `par_pop` removes it.
- R6: A call word that carries `cmd_last` launches the call. In the following cycle `mstart_valid` is 1 and `mstart_count` equals the number of words that call stored. The call then closes, so the next call must open on an even trigger.
- R7: The table entry of a call is ((trigger − 0xE00) >> 1) modulo POS_ENTRIES. `mstart_pos` carries the position stored at that entry.
- R8: Writing method 8 loads the upload pointer. Each write to method 9 stores its argument in program memory at the pointer, visible on `prog_rd_data`, and then increments the pointer. If the pointer is at or beyond PROG_DEPTH, the word is not stored and `err[3]` is set.
- R9: Writing method 10 loads the bind pointer. Each write to method 11 stores its argument into the position table at the pointer and increments it, wrapping modulo POS_ENTRIES.
- R10: A call word that arrives when the FIFO holds FIFO_DEPTH words is dropped and sets `err[4]`. The launch count then equals the number of words actually stored.
- R11: `mstart_valid`, `mstart_pos` and `mstart_count` hold until `mstart_ready` is seen. A new launch while a request is still waiting replaces it and sets `err[5]`.
- R12: Error bits are sticky. Once set, a bit stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_method | input | METH_W | Method index |
| cmd_arg | input | DW | Method argument |
| cmd_last | input | 1 | Last word of the batch |
| reg_rd_idx | input | log2(NUM_REGS) | Register file read index |
| reg_rd_data | output | DW | Register file read data |
| prog_rd_addr | input | log2(PROG_DEPTH) | Program memory read address |
| prog_rd_data | output | DW | Program memory read data |
| par_pop | input | 1 | Remove the oldest parameter word |
| par_data | output | DW | Oldest parameter word |
| par_empty | output | 1 | Parameter FIFO is empty |
| mstart_valid | output | 1 | Macro launch request |
| mstart_ready | input | 1 | Executor accepts the launch |
| mstart_pos | output | DW | Program position of the launched call |
| mstart_count | output | log2(FIFO_DEPTH+1) | Words stored by the launched call |
| err | output | 6 | Sticky errors: 0 bad register, 1 odd start, 2 sequence, 3 upload range, 4 FIFO overflow, 5 launch overrun |

## Verification
The hardest state to reach is a launch that arrives while an earlier request is still unaccepted, with the FIFO holding words from both calls. A second hard state is a single call that overfills the FIFO. The stimulus reaches the first by holding `mstart_ready` low across two back-to-back single-word calls. It reaches the second by streaming one trigger plus FIFO_DEPTH+1 argument words before the last flag. Random calls of random length use trigger indices beyond the table size, which exercises the entry modulo against a bench-side model of the bound positions.

// File: rtl/cmd_dispatch_pkg.sv
package cmd_dispatch_pkg;
   localparam int ERR_W = 6;
   typedef enum int unsigned {
      E_BADREG = 0,
      E_ODD    = 1,
      E_SEQ    = 2,
      E_PROG   = 3,
      E_OVF    = 4,
      E_OVR    = 5
   } err_bit_e;
endpackage

// File: rtl/cmd_reg_file.sv
module cmd_reg_file #(
   parameter int NUM_REGS = 64,
   parameter int DW       = 32,
   localparam int RA_W    = $clog2(NUM_REGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RA_W-1:0] widx,
   input  logic [DW-1:0]   wdata,
   input  logic [RA_W-1:0] ridx,
   output logic [DW-1:0]   rdata
);
   logic [DW-1:0] regs_q [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      end else if (we) begin
         regs_q[widx] <= wdata;
      end
   end

   always_comb rdata = (int'(ridx) < NUM_REGS) ? regs_q[ridx] : '0;
endmodule

// File: rtl/cmd_param_fifo.sv
module cmd_param_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] level
);
   localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] lvl_q;
   logic          pop_ok;

   assign pop_ok = pop && (lvl_q != '0);

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (push)   wp_q <= (wp_q == LAST_A) ? '0 : wp_q + 1'b1;
         if (pop_ok) rp_q <= (rp_q == LAST_A) ? '0 : rp_q + 1'b1;
         lvl_q <= lvl_q + CW'(push) - CW'(pop_ok);
      end
   end

   assign dout  = mem_q[rp_q];
   assign level = lvl_q;
endmodule

// File: rtl/cmd_macro_store.sv
module cmd_macro_store #(
   parameter int PROG_DEPTH  = 64,
   parameter int POS_ENTRIES = 16,
   parameter int DW          = 32,
   localparam int PA_W       = $clog2(PROG_DEPTH),
   localparam int ENT_W      = (POS_ENTRIES > 1) ? $clog2(POS_ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    arg,
   input  logic             ld_up,
   input  logic             wr_up,
   input  logic             ld_bind,
   input  logic             wr_bind,
   input  logic [ENT_W-1:0] entry_sel,
   output logic [DW-1:0]    pos_out,
   input  logic [PA_W-1:0]  prog_rd_addr,
   output logic [DW-1:0]    prog_rd_data,
   output logic             up_oob
);
   logic [DW-1:0]    prog_q [PROG_DEPTH];
   logic [DW-1:0]    pos_q  [POS_ENTRIES];
   logic [DW-1:0]    up_ptr_q;
   logic [ENT_W-1:0] bind_ptr_q;
   logic             up_in_range;

   assign up_in_range = up_ptr_q < DW'(PROG_DEPTH);
   assign up_oob      = wr_up && !up_in_range;

   always_ff @(posedge clk) begin
      if (wr_up && up_in_range) prog_q[up_ptr_q[PA_W-1:0]] <= arg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_ptr_q   <= '0;
         bind_ptr_q <= '0;
      end else begin
         if (ld_up)                      up_ptr_q   <= arg;
         else if (wr_up && up_in_range)  up_ptr_q   <= up_ptr_q + 1'b1;
         if (ld_bind)                    bind_ptr_q <= arg[ENT_W-1:0];
         else if (wr_bind)               bind_ptr_q <= bind_ptr_q + 1'b1;
      end
   end

   for (genvar g = 0; g < POS_ENTRIES; g++) begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    pos_q[g] <= '0;
         else if (wr_bind && bind_ptr_q == ENT_W'(g))   pos_q[g] <= arg;
      end
   end

   assign pos_out      = pos_q[entry_sel];
   assign prog_rd_data = prog_q[prog_rd_addr];
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
   import cmd_dispatch_pkg::*;
#(
   parameter int METH_W       = 12,
   parameter int DW           = 32,
   parameter int NUM_REGS     = 64,
   parameter int MACRO_BASE   = 'hE00,
   parameter int FIFO_DEPTH   = 32,
   parameter int PROG_DEPTH   = 64,
   parameter int POS_ENTRIES  = 16,
   parameter int IDX_UPADDR   = 8,
   parameter int IDX_UPDATA   = 9,
   parameter int IDX_BINDPTR  = 10,
   parameter int IDX_BINDDATA = 11,
   localparam int RA_W        = $clog2(NUM_REGS),
   localparam int PA_W        = $clog2(PROG_DEPTH),
   localparam int CNT_W       = $clog2(FIFO_DEPTH + 1),
   localparam int ENT_W       = (POS_ENTRIES > 1) ? $clog2(POS_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [METH_W-1:0] cmd_method,
   input  logic [DW-1:0]     cmd_arg,
   input  logic              cmd_last,
   input  logic [RA_W-1:0]   reg_rd_idx,
   output logic [DW-1:0]     reg_rd_data,
   input  logic [PA_W-1:0]   prog_rd_addr,
   output logic [DW-1:0]     prog_rd_data,
   input  logic              par_pop,
   output logic [DW-1:0]     par_data,
   output logic              par_empty,
   output logic              mstart_valid,
   input  logic              mstart_ready,
   output logic [DW-1:0]     mstart_pos,
   output logic [CNT_W-1:0]  mstart_count,
   output logic [ERR_W-1:0]  err
);
   localparam logic [METH_W-1:0] BASE_V  = METH_W'(MACRO_BASE);
   localparam logic [METH_W-1:0] NREG_V  = METH_W'(NUM_REGS);
   localparam logic [METH_W-1:0] ONE_M   = METH_W'(1);
   localparam logic [METH_W-1:0] UPA_V   = METH_W'(IDX_UPADDR);
   localparam logic [METH_W-1:0] UPD_V   = METH_W'(IDX_UPDATA);
   localparam logic [METH_W-1:0] BNP_V   = METH_W'(IDX_BINDPTR);
   localparam logic [METH_W-1:0] BND_V   = METH_W'(IDX_BINDDATA);
   localparam logic [CNT_W-1:0]  FULL_V  = CNT_W'(FIFO_DEPTH);

   initial begin
      assert ((1 << ENT_W) == POS_ENTRIES) else $error("POS_ENTRIES must be a power of two");
      assert (MACRO_BASE % 2 == 0)         else $error("MACRO_BASE must be even");
      assert (NUM_REGS <= MACRO_BASE)      else $error("register file overlaps macro range");
      assert (MACRO_BASE < (1 << METH_W))  else $error("MACRO_BASE exceeds method width");
      assert (IDX_BINDDATA < NUM_REGS)     else $error("side-effect index outside register file");
   end

   logic              busy_q;
   logic [METH_W-1:0] trig_q;
   logic [CNT_W-1:0]  call_cnt_q;
   logic              ms_valid_q;
   logic [DW-1:0]     ms_pos_q;
   logic [CNT_W-1:0]  ms_cnt_q;
   logic [ERR_W-1:0]  err_q, err_set;

   logic              is_macro, seq_bad, odd_start, bad_reg;
   logic              reg_ok, macro_ok, push_ok, fifo_full, launch;
   logic [METH_W-1:0] call_trig;
   logic [ENT_W-1:0]  entry_sel;
   logic [DW-1:0]     pos_sel;
   logic [CNT_W-1:0]  fifo_level, launch_cnt;
   logic              up_oob;

   // ---- command classification ----
   always_comb begin
      is_macro  = cmd_method >= BASE_V;
      seq_bad   = cmd_valid &&  busy_q && (cmd_method != trig_q + ONE_M);
      odd_start = cmd_valid && !busy_q && is_macro && cmd_method[0];
      bad_reg   = cmd_valid && !busy_q && !is_macro && (cmd_method >= NREG_V);
      reg_ok    = cmd_valid && !busy_q && !is_macro && (cmd_method < NREG_V);
      macro_ok  = cmd_valid && is_macro && !seq_bad && !odd_start;
      fifo_full = fifo_level == FULL_V;
      push_ok   = macro_ok && !fifo_full;
      launch    = macro_ok && cmd_last;
      call_trig = busy_q ? trig_q : cmd_method;
      entry_sel = ENT_W'((call_trig - BASE_V) >> 1);
      launch_cnt = call_cnt_q + CNT_W'(push_ok);
   end

   // ---- macro call sequencer ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         trig_q     <= '0;
         call_cnt_q <= '0;
      end else if (macro_ok) begin
         if (cmd_last) begin
            busy_q     <= 1'b0;
            trig_q     <= '0;
            call_cnt_q <= '0;
         end else begin
            busy_q     <= 1'b1;
            trig_q     <= call_trig;
            call_cnt_q <= launch_cnt;
         end
      end
   end

   // ---- launch request register ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_valid_q <= 1'b0;
         ms_pos_q   <= '0;
         ms_cnt_q   <= '0;
      end else if (launch) begin
         ms_valid_q <= 1'b1;
         ms_pos_q   <= pos_sel;
         ms_cnt_q   <= launch_cnt;
      end else if (ms_valid_q && mstart_ready) begin
         ms_valid_q <= 1'b0;
      end
   end

   // ---- sticky errors ----
   always_comb begin
      err_set           = '0;
      err_set[E_BADREG] = bad_reg;
      err_set[E_ODD]    = odd_start;
      err_set[E_SEQ]    = seq_bad;
      err_set[E_PROG]   = up_oob;
      err_set[E_OVF]    = macro_ok && fifo_full;
      err_set[E_OVR]    = launch && ms_valid_q && !mstart_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= err_q | err_set;
   end

   // ---- datapath pieces ----
   cmd_reg_file #(.NUM_REGS(NUM_REGS), .DW(DW)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_ok),
      .widx  (cmd_method[RA_W-1:0]),
      .wdata (cmd_arg),
      .ridx  (reg_rd_idx),
      .rdata (reg_rd_data)
   );

   cmd_param_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .din   (cmd_arg),
      .pop   (par_pop),
      .dout  (par_data),
      .level (fifo_level)
   );

   cmd_macro_store #(.PROG_DEPTH(PROG_DEPTH), .POS_ENTRIES(POS_ENTRIES), .DW(DW)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .arg          (cmd_arg),
      .ld_up        (reg_ok && cmd_method == UPA_V),
      .wr_up        (reg_ok && cmd_method == UPD_V),
      .ld_bind      (reg_ok && cmd_method == BNP_V),
      .wr_bind      (reg_ok && cmd_method == BND_V),
      .entry_sel    (entry_sel),
      .pos_out      (pos_sel),
      .prog_rd_addr (prog_rd_addr),
      .prog_rd_data (prog_rd_data),
      .up_oob       (up_oob)
   );

   assign par_empty    = fifo_level == '0;
   assign mstart_valid = ms_valid_q;
   assign mstart_pos   = ms_pos_q;
   assign mstart_count = ms_cnt_q;
   assign err          = err_q;
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk #(
   parameter int METH_W     = 12,
   parameter int DW         = 32,
   parameter int CNT_W      = 6,
   parameter int ERR_W      = 6,
   parameter int FIFO_DEPTH = 32,
   parameter int MACRO_BASE = 'hE00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [METH_W-1:0] cmd_method,
   input logic              cmd_last,
   input logic              busy,
   input logic [METH_W-1:0] trig,
   input logic              mstart_valid,
   input logic              mstart_ready,
   input logic [DW-1:0]     mstart_pos,
   input logic [CNT_W-1:0]  mstart_count,
   input logic [ERR_W-1:0]  err,
   input logic [CNT_W-1:0]  fifo_level
);
   localparam logic [METH_W-1:0] BASE_V  = METH_W'(MACRO_BASE);
   localparam logic [METH_W-1:0] ONE_M   = METH_W'(1);
   localparam logic [CNT_W-1:0]  DEPTH_V = CNT_W'(FIFO_DEPTH);

   AST_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && cmd_method >= BASE_V && cmd_method[0]) |=> err[1]); // R3
   AST_SEQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy && cmd_method != trig + ONE_M) |=> err[2]); // R4
   AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mstart_valid) |-> $past(cmd_valid && cmd_last && cmd_method >= BASE_V)); // R6
   AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_last && busy && cmd_method == trig + ONE_M) |=> !busy); // R6
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mstart_valid |-> (mstart_count != '0 && mstart_count <= DEPTH_V)); // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= DEPTH_V); // R10
   AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (mstart_valid && !mstart_ready) |=> mstart_valid); // R11
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mstart_valid && !mstart_ready && !(cmd_valid && cmd_last && cmd_method >= BASE_V))
      |=> ($stable(mstart_pos) && $stable(mstart_count))); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err != '0) |=> ((err & $past(err)) == $past(err))); // R12
endmodule

bind cmd_dispatch cmd_dispatch_chk #(
   .METH_W(METH_W), .DW(DW), .CNT_W(CNT_W), .ERR_W(cmd_dispatch_pkg::ERR_W),
   .FIFO_DEPTH(FIFO_DEPTH), .MACRO_BASE(MACRO_BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_method   (cmd_method),
   .cmd_last     (cmd_last),
   .busy         (busy_q),
   .trig         (trig_q),
   .mstart_valid (mstart_valid),
   .mstart_ready (mstart_ready),
   .mstart_pos   (mstart_pos),
   .mstart_count (mstart_count),
   .err          (err),
   .fifo_level   (fifo_level)
);

// File: tb/cmd_dispatch_bench.sv
`timescale 1ns/1ps
module cmd_dispatch_bench;
   localparam int METH_W = 12;
   localparam int DW     = 32;
   localparam int NREG   = 64;
   localparam int DEPTH  = 32;
   localparam int NPOS   = 16;
   localparam logic [METH_W-1:0] BASE = 12'hE00;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [METH_W-1:0] cmd_method = '0;
   logic [DW-1:0]     cmd_arg = '0;
   logic              cmd_last = 1'b0;
   logic [5:0]        reg_rd_idx = '0;
   logic [DW-1:0]     reg_rd_data;
   logic [5:0]        prog_rd_addr = '0;
   logic [DW-1:0]     prog_rd_data;
   logic              par_pop = 1'b0;
   logic [DW-1:0]     par_data;
   logic              par_empty;
   logic              mstart_valid;
   logic              mstart_ready = 1'b0;
   logic [DW-1:0]     mstart_pos;
   logic [5:0]        mstart_count;
   logic [5:0]        err;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [DW-1:0] reg_model [NREG];
   logic [DW-1:0] pos_model [NPOS];
   logic [5:0]    exp_err = '0;
   logic [DW-1:0] words [40];

   always #4 clk = ~clk;

   cmd_dispatch u_cmd_dispatch (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_method(cmd_method),
      .cmd_arg(cmd_arg), .cmd_last(cmd_last), .reg_rd_idx(reg_rd_idx),
      .reg_rd_data(reg_rd_data), .prog_rd_addr(prog_rd_addr), .prog_rd_data(prog_rd_data),
      .par_pop(par_pop), .par_data(par_data), .par_empty(par_empty),
      .mstart_valid(mstart_valid), .mstart_ready(mstart_ready), .mstart_pos(mstart_pos),
      .mstart_count(mstart_count), .err(err)
   );

   function automatic logic [DW-1:0] bind_val(int e);
      return 32'h0000_1000 + 32'(e * 7);
   endfunction

   function automatic int entry_of(logic [METH_W-1:0] trig);
      return ((int'(trig) - int'(BASE)) >> 1) % NPOS;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [METH_W-1:0] m, input logic [DW-1:0] a, input logic last);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_method = m; cmd_arg = a; cmd_last = last;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_last = 1'b0;
   endtask

   task automatic pop_chk(input string tag, input logic [DW-1:0] exp);
      chk(tag, par_data, exp);
      par_pop = 1'b1;
      @(negedge clk);
      par_pop = 1'b0;
   endtask

   task automatic ack(input string tag);
      mstart_ready = 1'b1;
      @(negedge clk);
      mstart_ready = 1'b0;
      chk(tag, 32'(mstart_valid), 32'd0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NREG; i++) reg_model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 mstart_valid", 32'(mstart_valid), 32'd0);
      chk("R1 err", 32'(err), 32'd0);
      chk("R1 par_empty", 32'(par_empty), 32'd1);

      // R2: random register writes, avoiding side-effect indices 8..11
      for (int n = 0; n < 40; n++) begin
         int idx;
         logic [DW-1:0] v;
         do idx = int'($urandom % NREG); while (idx >= 8 && idx <= 11);
         v = $urandom;
         send(METH_W'(idx), v, 1'b0);
         reg_model[idx] = v;
      end
      for (int i = 0; i < NREG; i++) begin
         if (i >= 8 && i <= 11) continue;
         reg_rd_idx = 6'(i);
         #1;
         chk($sformatf("R2 reg %0d (R1 reset value if untouched)", i), reg_rd_data, reg_model[i]);
      end
      send(12'd100, 32'hDEAD, 1'b0);
      exp_err[0] = 1'b1;
      chk("R2 bad register flag", 32'(err), 32'(exp_err));

      // R8: program upload
      send(12'd8, 32'd0, 1'b0);
      send(12'd9, 32'hA000_0000, 1'b0);
      send(12'd9, 32'hA000_0001, 1'b0);
      send(12'd9, 32'hA000_0002, 1'b0);
      for (int i = 0; i < 3; i++) begin
         prog_rd_addr = 6'(i);
         #1;
         chk("R8 program word", prog_rd_data, 32'hA000_0000 + 32'(i));
      end
      send(12'd8, 32'd62, 1'b0);
      send(12'd9, 32'hB062, 1'b0);
      send(12'd9, 32'hB063, 1'b0);
      chk("R8 no range error yet", 32'(err), 32'(exp_err));
      send(12'd9, 32'hB064, 1'b0);
      exp_err[3] = 1'b1;
      chk("R8 range error", 32'(err), 32'(exp_err));
      prog_rd_addr = 6'd63; #1;
      chk("R8 last word", prog_rd_data, 32'hB063);

      // R9: bind table, including wrap back to entry 0
      send(12'd10, 32'd0, 1'b0);
      for (int e = 0; e < NPOS; e++) begin
         send(12'd11, bind_val(e), 1'b0);
         pos_model[e] = bind_val(e);
      end
      send(12'd11, 32'h0000_7777, 1'b0);
      pos_model[0] = 32'h0000_7777;

      // R5 R6 R7: single-word call on entry 0
      send(BASE, 32'h55, 1'b1);
      chk("R6 launch valid", 32'(mstart_valid), 32'd1);
      chk("R6 count one", 32'(mstart_count), 32'd1);
      chk("R9 wrapped entry 0 (R7)", mstart_pos, pos_model[0]);
      pop_chk("R5 first word", 32'h55);
      ack("R11 cleared on ready");

      // R5 R6 R7: random calls, entries beyond table size
      for (int n = 0; n < 12; n++) begin
         int e, len;
         logic [METH_W-1:0] trig;
         e = int'($urandom % 32);
         len = 1 + int'($urandom % 6);
         trig = BASE + METH_W'(2 * e);
         for (int k = 0; k < len; k++) words[k] = $urandom;
         send(trig, words[0], len == 1);
         for (int k = 1; k < len; k++) send(trig + 12'd1, words[k], k == len - 1);
         chk("R6 random launch", 32'(mstart_valid), 32'd1);
         chk("R6 random count", 32'(mstart_count), 32'(len));
         chk("R7 random entry position", mstart_pos, pos_model[entry_of(trig)]);
         for (int k = 0; k < len; k++) pop_chk("R5 random order", words[k]);
         chk("R5 drained", 32'(par_empty), 32'd1);
         ack("R11 random ack");
      end

      // R3: odd start dropped
      send(BASE + 12'd1, 32'h99, 1'b0);
      exp_err[1] = 1'b1;
      chk("R3 odd flag", 32'(err), 32'(exp_err));
      chk("R3 nothing pushed", 32'(par_empty), 32'd1);
      send(BASE + 12'd1, 32'h98, 1'b1);
      chk("R3 no launch", 32'(mstart_valid), 32'd0);

      // R4: wrong method mid-call dropped, call continues
      send(BASE + 12'd4, 32'h11, 1'b0);
      send(BASE + 12'd7, 32'h22, 1'b1);
      exp_err[2] = 1'b1;
      chk("R4 sequence flag", 32'(err), 32'(exp_err));
      chk("R4 no launch", 32'(mstart_valid), 32'd0);
      send(12'd20, 32'h44, 1'b0);
      reg_rd_idx = 6'd20; #1;
      chk("R4 register write dropped", reg_rd_data, reg_model[20]);
      send(BASE + 12'd5, 32'h33, 1'b1);
      chk("R4 launch count", 32'(mstart_count), 32'd2);
      chk("R7 entry 2", mstart_pos, pos_model[2]);
      pop_chk("R4 word a", 32'h11);
      pop_chk("R4 word b", 32'h33);
      ack("R4 ack");

      // R10: overflow in a single call
      for (int k = 0; k < 34; k++) words[k] = 32'hC000_0000 + 32'(k);
      send(BASE + 12'd16, words[0], 1'b0);
      for (int k = 1; k < 34; k++) send(BASE + 12'd17, words[k], k == 33);
      exp_err[4] = 1'b1;
      chk("R10 overflow flag", 32'(err), 32'(exp_err));
      chk("R10 count saturates", 32'(mstart_count), 32'(DEPTH));
      for (int k = 0; k < DEPTH; k++) pop_chk("R10 stored words", words[k]);
      chk("R10 drained", 32'(par_empty), 32'd1);
      ack("R10 ack");

      // R11: hold then overrun
      send(BASE, 32'h1, 1'b1);
      repeat (3) @(negedge clk);
      chk("R11 held valid", 32'(mstart_valid), 32'd1);
      chk("R11 held position", mstart_pos, pos_model[0]);
      send(BASE + 12'd2, 32'h2, 1'b1);
      exp_err[5] = 1'b1;
      chk("R11 overrun flag", 32'(err), 32'(exp_err));
      chk("R11 replaced position", mstart_pos, pos_model[1]);
      pop_chk("R11 word a", 32'h1);
      pop_chk("R11 word b", 32'h2);
      ack("R11 ack");

      // R12: legal traffic leaves errors set
      send(12'd30, 32'h5, 1'b0);
      send(BASE, 32'h6, 1'b1);
      pop_chk("R12 word", 32'h6);
      ack("R12 ack");
      chk("R12 sticky", 32'(err), 32'(exp_err));

      done = 1;
      summary();
      $finish;
   end
endmodule